// File: doc/BRIEF.md
# Partitioned Multi-Lane Array Store

This block holds a logical array of `N` data words spread over several small memories (banks), so that a single request can touch up to `LANES` consecutive elements at once. A compile-time parameter selects how elements are spread. Block spreading gives each bank one contiguous run of elements. Cyclic spreading interleaves elements across `P` banks. Complete spreading gives every element its own register.

A request carries a start index, a per-lane enable mask, a read/write flag and one data word per lane. Lane `l` always addresses element `start + l`. Each lane's index is turned into a bank number and an in-bank offset. A scheduler then grants the lanes to the banks. Each bank has two ports, so it can take at most two accesses in one cycle. When more lanes land on one bank, the request is spread over extra cycles. The requester sees a valid/ready handshake on the way in and a single response pulse carrying the read data of all lanes.

A read-only build turns the banks into constant tables. Their contents come from a parameter, and writes do not change them.

Top module: `banked_array_mem`

## Requirements
- R1: With cyclic spreading, element `i` is held in bank `i mod P` at offset `i div P`. With `P = 2`, reading elements 0 to 3 needs one issue cycle, so the response pulse comes 2 clock edges after the accepting edge.
- R2: With block spreading, bank `k` holds elements `k*B` to `k*B+B-1`, where `B = ceil(N/P)`. With `N = 11` and `P = 2`, reading elements 0 to 3 needs two issue cycles, so the response comes 3 edges after acceptance.
- R3: With complete spreading, all enabled lanes are issued in one cycle for any start index, so the response comes 2 edges after acceptance.
- R4: A bank serves at most two lanes per cycle. Colliding lanes are served lowest lane first. The number of issue cycles is the largest per-bank value of ceil(lanes on that bank / 2), with a minimum of 1. The response comes that many cycles plus one edge after acceptance.
- R5: A write stores lane `l`'s word, taken from `req_wdata[l*DW +: DW]`, into element `start + l`. A later read returns it in `rsp_rdata[l*DW +: DW]`. A write response carries all-zero read data.
- R6: A lane whose `req_lane_en[l]` bit is 0 neither reads nor writes, and its read data field is 0.
- R7: Read data is returned in lane order, and `rsp_valid` is high for exactly one cycle per accepted request.
- R8: `req_ready` is low from the accepting edge until the edge that raises `rsp_valid`, and high in the cycle of the pulse.
- R9: An enabled lane whose index is `N` or more sets `rsp_err` for that request. That lane accesses nothing and its read data field is 0. The in-range lanes of the same request still complete.
- R10: When `N` is not a multiple of `P`, every index up to `N-1` maps to a valid location in both block and cyclic spreading.
- R11: With `READ_ONLY` set, element `i` reads as `INIT[i*DW +: DW]` and write requests leave every element unchanged.
- R12: After synchronous reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_start | input | clog2(N) | Element index addressed by lane 0 |
| req_lane_en | input | LANES | Per-lane enable |
| req_wdata | input | LANES*DW | Write words, lane l at [l*DW +: DW] |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | An enabled lane was out of range |
| rsp_rdata | output | LANES*DW | Read words, lane l at [l*DW +: DW] |

## Verification
The hardest case to reach is a bank collision that stretches a request over several cycles. In that case the read data of earlier-issued lanes must be kept while later lanes are still in flight, and the response must wait for the last lane. The bench drives the same request into a cyclic, a block, a complete and a read-only instance at once. Start indices are chosen so that three or four lanes fall into one block-mode bank. The bench also uses the short final bank at `N-1` and starts that run past the end of the array. For each instance, the expected number of cycles comes from counting lanes per bank.

// File: rtl/bam_pkg.sv
package bam_pkg;

  typedef enum logic [1:0] {
    SCH_BLOCK    = 2'd0,
    SCH_CYCLIC   = 2'd1,
    SCH_COMPLETE = 2'd2
  } scheme_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } bam_state_e;

  function automatic int num_banks(scheme_e s, int n, int p);
    return (s == SCH_COMPLETE) ? n : p;
  endfunction

  function automatic int bank_depth(scheme_e s, int n, int p);
    return (s == SCH_COMPLETE) ? 1 : (n + p - 1) / p;
  endfunction

  // Element index stored at offset o of bank b (inverse of the mapping)
  function automatic int elem_at(scheme_e s, int n, int p, int b, int o);
    int d;
    d = bank_depth(s, n, p);
    case (s)
      SCH_BLOCK:  return b * d + o;
      SCH_CYCLIC: return o * p + b;
      default:    return b;
    endcase
  endfunction

endpackage

// File: rtl/bam_addr_map.sv
module bam_addr_map #(
  parameter bam_pkg::scheme_e SCHEME = bam_pkg::SCH_CYCLIC,
  parameter int N  = 11,
  parameter int P  = 2,
  parameter int XW = 7,
  parameter int BW = 1,
  parameter int OW = 3
) (
  input  logic [XW-1:0] idx,
  output logic [BW-1:0] bank,
  output logic [OW-1:0] off,
  output logic          oor
);
  localparam int D = bam_pkg::bank_depth(SCHEME, N, P);

  assign oor = (idx >= XW'(N));

  if (SCHEME == bam_pkg::SCH_BLOCK) begin : g_block
    always_comb begin
      bank = oor ? '0 : BW'(idx / XW'(D));
      off  = oor ? '0 : OW'(idx % XW'(D));
    end
  end else if (SCHEME == bam_pkg::SCH_CYCLIC) begin : g_cyclic
    always_comb begin
      bank = oor ? '0 : BW'(idx % XW'(P));
      off  = oor ? '0 : OW'(idx / XW'(P));
    end
  end else begin : g_complete
    always_comb begin
      bank = oor ? '0 : BW'(idx);
      off  = '0;
    end
  end

endmodule

// File: rtl/bam_sched.sv
module bam_sched #(
  parameter int LANES = 4,
  parameter int NB    = 2,
  parameter int BW    = 1,
  parameter int LW    = 2
) (
  input  logic [LANES-1:0] pend,
  input  logic [BW-1:0]    lane_bank [LANES],
  output logic [LANES-1:0] grant,
  output logic [LANES-1:0] lane_port,
  output logic             port_vld  [NB][2],
  output logic [LW-1:0]    port_lane [NB][2]
);

  // Per bank: first two pending lanes, lowest lane number first
  always_comb begin
    grant     = '0;
    lane_port = '0;
    for (int b = 0; b < NB; b++) begin
      port_vld[b][0]  = 1'b0;
      port_vld[b][1]  = 1'b0;
      port_lane[b][0] = '0;
      port_lane[b][1] = '0;
    end
    for (int b = 0; b < NB; b++) begin : g_scan
      int used;
      used = 0;
      for (int l = 0; l < LANES; l++) begin
        if (pend[l] && lane_bank[l] == BW'(b) && used < 2) begin
          port_vld[b][used]  = 1'b1;
          port_lane[b][used] = LW'(l);
          grant[l]           = 1'b1;
          lane_port[l]       = used[0];
          used               = used + 1;
        end
      end
    end
  end

endmodule

// File: rtl/bam_bank.sv
module bam_bank #(
  parameter bam_pkg::scheme_e SCHEME = bam_pkg::SCH_CYCLIC,
  parameter int N     = 11,
  parameter int P     = 2,
  parameter int DW    = 16,
  parameter int DEPTH = 6,
  parameter int AW    = 3,
  parameter int BIDX  = 0,
  parameter logic [N*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en    [2],
  input  logic          we    [2],
  input  logic [AW-1:0] addr  [2],
  input  logic [DW-1:0] wdata [2],
  output logic [DW-1:0] rdata [2]
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int o = 0; o < DEPTH; o++) begin
      int e;
      e = bam_pkg::elem_at(SCHEME, N, P, BIDX, o);
      mem[o] = (e < N) ? INIT[e*DW +: DW] : '0;
    end
  end

  // Two ports, registered read, old data returned on a same-cycle write
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (en[p]) begin
        rdata[p] <= mem[addr[p]];
        if (we[p]) mem[addr[p]] <= wdata[p];
      end
    end
  end

  // R4: the two ports never write one location in the same cycle
  p_port_clash_r4: assert property (@(posedge clk) disable iff (rst)
    (en[0] && en[1] && we[0] && we[1]) |-> (addr[0] != addr[1]));

endmodule

// File: rtl/banked_array_mem.sv
module banked_array_mem #(
  parameter bam_pkg::scheme_e SCHEME = bam_pkg::SCH_CYCLIC,
  parameter int N     = 11,
  parameter int P     = 2,
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter bit READ_ONLY = 1'b0,
  parameter logic [N*DW-1:0] INIT = '0,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [SW-1:0]       req_start,
  input  logic [LANES-1:0]    req_lane_en,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [LANES*DW-1:0] rsp_rdata
);
  import bam_pkg::*;

  localparam int NB = num_banks(SCHEME, N, P);
  localparam int D  = bank_depth(SCHEME, N, P);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int XW = SW + LW + 1;

  bam_state_e           st;
  logic [SW-1:0]        start_q;
  logic                 wr_q;
  logic [LANES-1:0]     en_q;
  logic [LANES-1:0]     done_q;
  logic [LANES-1:0]     grant_q;
  logic [LANES-1:0]     port_q;
  logic [DW-1:0]        wdata_q [LANES];
  logic [DW-1:0]        res     [LANES];

  logic [XW-1:0]        lane_idx  [LANES];
  logic [BW-1:0]        lane_bank [LANES];
  logic [AW-1:0]        lane_off  [LANES];
  logic [LANES-1:0]     lane_oor;
  logic [LANES-1:0]     pend_c;
  logic [LANES-1:0]     sched_pend;
  logic [LANES-1:0]     grant;
  logic [LANES-1:0]     lane_port;
  logic                 port_vld  [NB][2];
  logic [LW-1:0]        port_lane [NB][2];
  logic [DW-1:0]        bk_rd     [NB][2];

  // Index mapping, one unit per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_idx[l] = XW'(start_q) + XW'(l);
    bam_addr_map #(.SCHEME(SCHEME), .N(N), .P(P), .XW(XW), .BW(BW), .OW(AW)) u_map (
      .idx (lane_idx[l]),
      .bank(lane_bank[l]),
      .off (lane_off[l]),
      .oor (lane_oor[l])
    );
    assign rsp_rdata[l*DW +: DW] = res[l];
  end

  assign pend_c     = en_q & ~lane_oor & ~done_q;
  assign sched_pend = (st == ST_BUSY) ? pend_c : '0;

  bam_sched #(.LANES(LANES), .NB(NB), .BW(BW), .LW(LW)) u_sched (
    .pend     (sched_pend),
    .lane_bank(lane_bank),
    .grant    (grant),
    .lane_port(lane_port),
    .port_vld (port_vld),
    .port_lane(port_lane)
  );

  // Banks with their port steering
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          en_p [2];
    logic          we_p [2];
    logic [AW-1:0] ad_p [2];
    logic [DW-1:0] wd_p [2];

    always_comb begin
      for (int p = 0; p < 2; p++) begin
        en_p[p] = (st == ST_BUSY) && port_vld[b][p];
        we_p[p] = wr_q && !READ_ONLY;
        ad_p[p] = lane_off[port_lane[b][p]];
        wd_p[p] = wdata_q[port_lane[b][p]];
      end
    end

    bam_bank #(.SCHEME(SCHEME), .N(N), .P(P), .DW(DW), .DEPTH(D), .AW(AW),
               .BIDX(b), .INIT(INIT)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .en   (en_p),
      .we   (we_p),
      .addr (ad_p),
      .wdata(wd_p),
      .rdata(bk_rd[b])
    );

    // R11: a read-only build never writes its tables
    p_rom_nowrite_r11: assert property (@(posedge clk) disable iff (rst)
      READ_ONLY |-> !((en_p[0] && we_p[0]) || (en_p[1] && we_p[1])));
  end

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      done_q    <= '0;
      grant_q   <= '0;
      port_q    <= '0;
      en_q      <= '0;
      wr_q      <= 1'b0;
      start_q   <= '0;
      for (int l = 0; l < LANES; l++) res[l] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      grant_q   <= (st == ST_BUSY && !wr_q) ? grant : '0;
      port_q    <= lane_port;
      for (int l = 0; l < LANES; l++) begin
        if (grant_q[l]) res[l] <= bk_rd[lane_bank[l]][port_q[l]];
      end
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st      <= ST_BUSY;
            start_q <= req_start;
            wr_q    <= req_write;
            en_q    <= req_lane_en;
            done_q  <= '0;
            for (int l = 0; l < LANES; l++) begin
              wdata_q[l] <= req_wdata[l*DW +: DW];
              res[l]     <= '0;
            end
          end
        end
        ST_BUSY: begin
          done_q <= done_q | grant;
          if ((pend_c & ~grant) == '0) st <= ST_DRAIN;
        end
        default: begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_err   <= |(en_q & lane_oor);
        end
      endcase
    end
  end

  // R8: acceptance drops ready on the following cycle
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8: ready was low in the cycle before the response pulse rises
  p_rsp_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(!req_ready));

  // R7: the completion pulse lasts one cycle
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4: grants only go to outstanding lanes, and some lane progresses
  p_grant_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY) |-> ((grant & ~pend_c) == '0));
  p_progress_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY && pend_c != '0) |-> (grant != '0));

  // R9: an out-of-range lane is never issued to a bank
  p_oor_untouched_r9: assert property (@(posedge clk) disable iff (rst)
    (grant & lane_oor) == '0);

endmodule

// File: tb/banked_array_mem_tb.sv
`timescale 1ns/1ps
module banked_array_mem_tb;
  import bam_pkg::*;

  localparam int N = 11;
  localparam int P = 2;
  localparam int LANES = 4;
  localparam int DW = 16;
  localparam int NI = 4;  // 0 cyclic, 1 block, 2 complete, 3 read-only cyclic

  function automatic logic [N*DW-1:0] mk_init();
    logic [N*DW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) r[i*DW +: DW] = 16'hA000 + 16'(i);
    return r;
  endfunction
  localparam logic [N*DW-1:0] ROM_INIT = mk_init();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [3:0] req_start = '0;
  logic [LANES-1:0] req_lane_en = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic rdy [NI];
  logic vld [NI];
  logic err [NI];
  logic [LANES*DW-1:0] rd [NI];

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mdl [N];

  always #2.5 clk = ~clk;

  banked_array_mem #(.SCHEME(SCH_CYCLIC), .N(N), .P(P), .LANES(LANES), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[0]), .req_write(req_write),
    .req_start(req_start), .req_lane_en(req_lane_en), .req_wdata(req_wdata),
    .rsp_valid(vld[0]), .rsp_err(err[0]), .rsp_rdata(rd[0]));
  banked_array_mem #(.SCHEME(SCH_BLOCK), .N(N), .P(P), .LANES(LANES), .DW(DW)) u_blk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[1]), .req_write(req_write),
    .req_start(req_start), .req_lane_en(req_lane_en), .req_wdata(req_wdata),
    .rsp_valid(vld[1]), .rsp_err(err[1]), .rsp_rdata(rd[1]));
  banked_array_mem #(.SCHEME(SCH_COMPLETE), .N(N), .P(P), .LANES(LANES), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[2]), .req_write(req_write),
    .req_start(req_start), .req_lane_en(req_lane_en), .req_wdata(req_wdata),
    .rsp_valid(vld[2]), .rsp_err(err[2]), .rsp_rdata(rd[2]));
  banked_array_mem #(.SCHEME(SCH_CYCLIC), .N(N), .P(P), .LANES(LANES), .DW(DW),
                     .READ_ONLY(1'b1), .INIT(ROM_INIT)) u_rom (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[3]), .req_write(req_write),
    .req_start(req_start), .req_lane_en(req_lane_en), .req_wdata(req_wdata),
    .rsp_valid(vld[3]), .rsp_err(err[3]), .rsp_rdata(rd[3]));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Expected edges from acceptance to response, counted per bank (R1-style rules)
  function automatic int exp_lat(int inst, int start, logic [3:0] en);
    int cnt [N];
    int s;
    s = 1;
    for (int b = 0; b < N; b++) cnt[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      int idx;
      int b;
      idx = start + l;
      if (en[l] && idx < N) begin
        b = (inst == 1) ? idx / ((N + P - 1) / P) : (inst == 2) ? idx : idx % P;
        cnt[b]++;
      end
    end
    for (int b = 0; b < N; b++) if ((cnt[b] + 1) / 2 > s) s = (cnt[b] + 1) / 2;
    return s + 1;
  endfunction

  function automatic string lat_tag(int inst);
    case (inst)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic do_req(input bit wr, input int start, input logic [3:0] en,
                        input logic [63:0] wd, input string dtag);
    int  lat [NI];
    bit  got [NI];
    bit  all_got;
    bit  exp_err;
    logic [63:0] exp_d;
    for (int i = 0; i < NI; i++) begin got[i] = 0; lat[i] = 0; end
    @(negedge clk);
    req_write = wr; req_start = 4'(start); req_lane_en = en; req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    all_got = 0;
    for (int k = 1; k <= 40 && !all_got; k++) begin
      @(posedge clk);
      #1;
      all_got = 1;
      for (int i = 0; i < NI; i++) begin
        if (!got[i]) begin
          if (vld[i]) begin
            got[i] = 1; lat[i] = k;
            chk(rdy[i] == 1'b1, "R8", "ready in pulse cycle", 64'(rdy[i]), 64'd1);
          end else begin
            chk(rdy[i] == 1'b0, "R8", "ready while busy", 64'(rdy[i]), 64'd0);
            all_got = 0;
          end
        end else begin
          chk(vld[i] == 1'b0, "R7", "pulse width", 64'(vld[i]), 64'd0);
        end
      end
    end
    exp_err = 0;
    for (int l = 0; l < LANES; l++) if (en[l] && start + l >= N) exp_err = 1;
    for (int i = 0; i < NI; i++) begin
      chk(got[i], "R8", $sformatf("response seen inst%0d", i), 64'(got[i]), 64'd1);
      chk(lat[i] == exp_lat(i, start, en), lat_tag(i), $sformatf("latency inst%0d", i),
          64'(lat[i]), 64'(exp_lat(i, start, en)));
      chk(err[i] == exp_err, "R9", $sformatf("error flag inst%0d", i),
          64'(err[i]), 64'(exp_err));
      exp_d = '0;
      for (int l = 0; l < LANES; l++) begin
        int idx;
        idx = start + l;
        if (!wr && en[l] && idx < N)
          exp_d[l*DW +: DW] = (i == 3) ? ROM_INIT[idx*DW +: DW] : mdl[idx];
      end
      chk(rd[i] == exp_d, (i == 3) ? "R11" : dtag, $sformatf("data inst%0d", i), rd[i], exp_d);
    end
    if (wr) begin
      for (int l = 0; l < LANES; l++)
        if (en[l] && start + l < N) mdl[start + l] = wd[l*DW +: DW];
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < NI; i++) begin
      chk(rdy[i] == 1'b1, "R12", "ready after reset", 64'(rdy[i]), 64'd1);
      chk(vld[i] == 1'b0, "R12", "valid after reset", 64'(vld[i]), 64'd0);
    end
  endtask

  task automatic t_fill();  // R5 writes, last chunk runs past the end (R9)
    do_req(1, 0, 4'hF, 64'h1003_1002_1001_1000, "R5");
    do_req(1, 4, 4'hF, 64'h1007_1006_1005_1004, "R5");
    do_req(1, 8, 4'hF, 64'h100B_100A_1009_1008, "R5");
  endtask

  task automatic t_read_lanes();  // R1 R2 R3 R7: first four elements, lane order
    do_req(0, 0, 4'hF, '0, "R7");
    do_req(0, 3, 4'hF, '0, "R4");
    do_req(0, 2, 4'hF, '0, "R4");
  endtask

  task automatic t_tail();  // R10: last elements, short final bank
    do_req(0, 7, 4'hF, '0, "R10");
    do_req(0, 10, 4'h1, '0, "R10");
  endtask

  task automatic t_oor();  // R9
    do_req(1, 9, 4'hF, 64'h2222_2222_2009_2008, "R9");
    do_req(0, 7, 4'hF, '0, "R9");
    do_req(1, 14, 4'hF, 64'hDEAD_DEAD_DEAD_DEAD, "R9");
    do_req(0, 14, 4'hF, '0, "R9");
    do_req(0, 0, 4'hF, '0, "R9");
    do_req(0, 8, 4'hF, '0, "R9");
  endtask

  task automatic t_lane_en();  // R6
    do_req(1, 0, 4'b0101, 64'h3333_3303_3333_3301, "R6");
    do_req(0, 0, 4'hF, '0, "R6");
    do_req(0, 0, 4'b0010, '0, "R6");
    do_req(0, 4, 4'b0000, '0, "R6");
  endtask

  task automatic t_rom_write();  // R11: writes leave the read-only build unchanged
    do_req(1, 4, 4'hF, 64'h4444_4443_4442_4441, "R5");
    do_req(0, 4, 4'hF, '0, "R5");
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R8 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_read_lanes();
    t_tail();
    t_oor();
    t_lane_en();
    t_rom_write();
    summary();
    $finish;
  end

endmodule